// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 x 8)

This block models a byte-wide nonvolatile memory of 256 locations that sits on a two-wire serial bus as a slave. Both bus lines are taken from open-drain pads. Each line passes through a two-flop synchronizer and is then sampled on the system clock. The block finds start and stop conditions and shifts bytes in and out. It acknowledges on the ninth clock of each byte. Its only drive on the data line is an active-low pull-down enable.

A master first sends a select byte. This byte carries a fixed device code, one chip-address bit that must equal a strap input, and a direction bit. A write transfer then sends a word address, followed by any number of data bytes, which land at consecutive locations. A read transfer returns bytes from the internal address counter.

When a stop ends a transfer that stored at least one byte, the block starts a self-timed programming cycle. While that cycle runs, the block ignores select bytes, so a master can poll for completion. A protect input blocks programming entirely.

Top module: `twi_eeprom`

## Requirements
- R1: A falling data line while the clock line is high (start) aborts any transfer in progress, including one cut off mid-byte, and makes the block expect a select byte. A rising data line while the clock line is high (stop) returns it to idle with the data line released.
- R2: A select byte is sent MSB first. Bits [7:2] must equal parameter DEV_CODE (default 6'b101000), bit 1 must equal `chipAddr`, and bit 0 is the direction (1 = read). A match is acknowledged by pulling the data line low through the ninth clock. On a mismatch the block never pulls the data line low until the next start.
- R3: In a write transfer, the byte after the select byte loads the 8-bit address counter and is acknowledged.
- R4: Each further byte of a write transfer is stored at the counter address and acknowledged, and the counter then increments. The counter wraps from 255 to 0.
- R5: After an acknowledged read select, the block drives the byte at the counter MSB first and increments the counter. It changes the data line only while the clock line is low, and releases the line during the ninth clock. When the master pulls the line low on that clock, the next byte follows, with the counter wrapping from 255 to 0.
- R6: A master that leaves the ninth clock high (no acknowledge) ends the read: the block releases the data line until the next start.
- R7: A read select sent with no preceding address continues from the current counter value.
- R8: A stop that ends a transfer which stored at least one byte starts a programming cycle of WRITE_CYCLES clocks. During that cycle, matching select bytes are not acknowledged. After the cycle they are acknowledged again.
- R9: While `protectIn` is high, data bytes of a write transfer are neither acknowledged nor stored, the counter does not advance, and no programming cycle starts.
- R10: After reset the data line is released, the block is idle, and no programming cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| chipAddr | input | 1 | Strap value that select-byte bit 1 must match |
| protectIn | input | 1 | High blocks all programming |
| sdaOeN | output | 1 | Low pulls the bus data line to 0; high releases it |

## Verification
The bench fills every one of the 256 locations in one long write burst. It then reads them all back in one burst of 257 bytes, so an address counter that fails to wrap, or that skips or repeats a step, shows up as a data mismatch. Busy polling is timed against the clock count: a design that starts no programming cycle would acknowledge the first poll, and one that never ends the cycle would never acknowledge. The bench also covers a protected write, a select byte with the wrong chip bit, and a start that cuts a data byte in half. A design that stored under protect, answered the wrong chip, or committed a partial byte would return altered data or pull the line low where it must stay released.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_RD
  } busState_t;

  // strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic shiftOut;   // advance the transmit bit
    logic loadTx;     // fetch array byte, bump counter
    logic loadAddr;   // counter <= received byte
    logic writeMem;   // array <= received byte, bump counter
    logic startTimer; // begin programming cycle
  } strobe_t;

endpackage

// File: rtl/twi_eeprom_dp.sv
module twi_eeprom_dp
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       rxBit,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]        shiftReg;
  logic [ADDR_W-1:0] addrCnt;
  logic [TMR_W-1:0]  timer;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrCnt  <= '0;
    end else begin
      if (strb.shiftIn)
        shiftReg <= {shiftReg[6:0], rxBit};
      else if (strb.shiftOut)
        shiftReg <= {shiftReg[6:0], 1'b0};
      else if (strb.loadTx)
        shiftReg <= mem[addrCnt];

      if (strb.loadAddr)
        addrCnt <= shiftReg[ADDR_W-1:0];
      else if (strb.loadTx || strb.writeMem)
        addrCnt <= addrCnt + 1'b1;
    end
  end

  // the array has no reset: it stands for nonvolatile cells
  always_ff @(posedge clk) begin
    if (strb.writeMem)
      mem[addrCnt] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      timer <= '0;
    else if (strb.startTimer)
      timer <= TMR_W'(WRITE_CYCLES);
    else if (timer != '0)
      timer <= timer - 1'b1;
  end

  assign busy   = (timer != '0);
  assign rxByte = shiftReg;
  assign txBit  = shiftReg[7];

  a_r4_addr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.writeMem) && $past(addrCnt) == {ADDR_W{1'b1}}) |-> addrCnt == '0);

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.startTimer |=> busy);

  a_r8_busy_counts_down: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.startTimer) |=> (timer < $past(timer)));

endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter logic [5:0] DEV_CODE = 6'b101000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       chipAddr,
  input  logic       protectIn,
  input  logic       busy,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    strb,
  output logic       rxBit,
  output logic       sdaOeN
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] sclSyncQ, sdaSyncQ;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t  state;
  logic [3:0] bitCnt;
  logic       ackOut, txEn, wrote, mAckN;
  logic       devMatch, byteDone, lastFall;

  // two-flop synchronizers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSyncQ <= '1;
      sdaSyncQ <= '1;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
    end else begin
      sclSyncQ <= {sclSyncQ[SYNC_N-2:0], sclIn};
      sdaSyncQ <= {sdaSyncQ[SYNC_N-2:0], sdaIn};
      sclP     <= sclSyncQ[SYNC_N-1];
      sdaP     <= sdaSyncQ[SYNC_N-1];
    end
  end

  assign sclS     = sclSyncQ[SYNC_N-1];
  assign sdaS     = sdaSyncQ[SYNC_N-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign rxBit    = sdaS;

  assign devMatch = (rxByte[7:2] == DEV_CODE) && (rxByte[1] == chipAddr);
  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign lastFall = sclFall && (bitCnt == 4'd9);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOut <= 1'b0;
      txEn   <= 1'b0;
      wrote  <= 1'b0;
      mAckN  <= 1'b1;
    end else if (startDet) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      ackOut <= 1'b0;
      txEn   <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOut <= 1'b0;
      txEn   <= 1'b0;
      wrote  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt != 4'd9)
          bitCnt <= bitCnt + 1'b1;
        // in read state the ninth-clock level decides whether to continue;
        // right after a read select it is the block's own acknowledge
        if (state == ST_RD && bitCnt == 4'd8)
          mAckN <= sdaS;
      end
      if (byteDone) begin
        case (state)
          ST_DEV: begin
            if (devMatch && !busy) begin
              ackOut <= 1'b1;
              state  <= rxByte[0] ? ST_RD : ST_ADDR;
            end else begin
              state  <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            ackOut <= 1'b1;
            state  <= ST_WR;
          end
          ST_WR: begin
            if (!protectIn) begin
              ackOut <= 1'b1;
              wrote  <= 1'b1;
            end
          end
          default: txEn <= 1'b0;
        endcase
      end
      if (lastFall) begin
        ackOut <= 1'b0;
        bitCnt <= '0;
        if (state == ST_RD) begin
          if (!mAckN) txEn  <= 1'b1;
          else        state <= ST_IDLE;
        end
      end
    end
  end

  always_comb begin
    strb = '0;
    if (!startDet && !stopDet) begin
      if ((state == ST_DEV || state == ST_ADDR || state == ST_WR) &&
          sclRise && bitCnt < 4'd8)
        strb.shiftIn = 1'b1;
      if (byteDone && state == ST_ADDR)
        strb.loadAddr = 1'b1;
      if (byteDone && state == ST_WR && !protectIn)
        strb.writeMem = 1'b1;
      if (state == ST_RD && sclFall && bitCnt >= 4'd1 && bitCnt <= 4'd7)
        strb.shiftOut = 1'b1;
      if (state == ST_RD && lastFall && !mAckN)
        strb.loadTx = 1'b1;
    end
    strb.startTimer = stopDet && wrote;
  end

  assign sdaOeN = ~(ackOut | (txEn & ~txBit));

  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOeN) |-> !sclS);

  a_r2_ack_in_ninth_clock: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> bitCnt >= 4'd8);

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (sdaOeN && state == ST_IDLE));

  a_r8_no_select_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && byteDone && busy) |=> !ackOut);

  a_r9_protect_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR && byteDone && protectIn) |=> !ackOut);

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter logic [5:0] DEV_CODE     = 6'b101000,
  parameter int         ADDR_W       = 8,
  parameter int         WRITE_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic chipAddr,
  input  logic protectIn,
  output logic sdaOeN
);
  strobe_t    strb;
  logic       rxBit, txBit, busy;
  logic [7:0] rxByte;

  twi_eeprom_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .chipAddr(chipAddr), .protectIn(protectIn), .busy(busy),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .rxBit(rxBit),
    .sdaOeN(sdaOeN)
  );

  twi_eeprom_dp #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(rxBit),
    .rxByte(rxByte), .txBit(txBit), .busy(busy)
  );

endmodule

// File: tb/twi_eeprom_bench.sv
`timescale 1ns/1ps
module twi_eeprom_bench;
  localparam int Q   = 4;     // clocks per quarter bus period
  localparam int WC  = 300;   // programming cycle length for the bench
  localparam int POLL_LEN = 176;
  localparam logic [7:0] DEVW  = 8'hA2;
  localparam logic [7:0] DEVR  = 8'hA3;
  localparam logic [7:0] WRONG = 8'hA0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic protectIn = 1'b0;
  logic sdaOeN;
  logic bus;
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign bus = sdaM & sdaOeN;

  twi_eeprom #(.WRITE_CYCLES(WC)) u_twi_eeprom (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(bus),
    .chipAddr(1'b1), .protectIn(protectIn), .sdaOeN(sdaOeN)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b0; qwait();
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b1; qwait(); qwait();
  endtask

  task automatic clockBit(input bit b, output bit seen);
    qwait(); sdaM = b;
    qwait(); sclM = 1'b1;
    qwait(); seen = bus;
    qwait(); sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    bit s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      b = {b[6:0], s};
    end
    clockBit(!giveAck, s);
  endtask

  task automatic pollReady(output int polls, output int waited);
    bit ack;
    int t0;
    t0 = cyc;
    polls = 0;
    do begin
      startCond(); sendByte(DEVW, ack); stopCond();
      polls++;
    end while (!ack && polls < 20);
    waited = cyc - t0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int polls, waited;

    repeat (5) @(negedge clk);
    chk(sdaOeN === 1'b1, "R10 released in reset", int'(sdaOeN), 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaOeN === 1'b1, "R10 released after reset", int'(sdaOeN), 1);

    // R4: fill the whole array in one burst from address 0
    startCond();
    sendByte(DEVW, ack); chk(ack, "R2 write select ack", ack, 1);
    sendByte(8'h00, ack); chk(ack, "R3 address ack", ack, 1);
    for (int a = 0; a < 256; a++) begin
      sendByte(pat(a), ack);
      chk(ack, "R4 data ack", a, 1);
    end
    stopCond();

    // R8: busy polling after the burst
    pollReady(polls, waited);
    chk(polls > 1, "R8 first poll not acknowledged", polls, 2);
    chk(waited >= WC && waited <= WC + 2 * POLL_LEN, "R8 cycle length",
        waited, WC);

    // R5: random read of all 257 bytes, last one wraps to address 0
    startCond();
    sendByte(DEVW, ack); chk(ack, "R2 select ack", ack, 1);
    sendByte(8'h00, ack); chk(ack, "R3 address ack", ack, 1);
    startCond();
    sendByte(DEVR, ack); chk(ack, "R2 read select ack", ack, 1);
    for (int a = 0; a < 257; a++) begin
      recvByte(a != 256, b);
      chk(b == pat(a % 256), "R5 read data", b, pat(a % 256));
    end
    // R6: after master no-ack the line stays released
    qwait();
    chk(sdaOeN === 1'b1, "R6 released after no-ack", int'(sdaOeN), 1);
    stopCond();

    // R7: current-address read continues at 1
    startCond();
    sendByte(DEVR, ack); chk(ack, "R7 select ack", ack, 1);
    recvByte(1'b0, b);
    chk(b == pat(1), "R7 current address data", b, pat(1));
    stopCond();

    // R2: wrong chip bit is ignored, line never pulled low
    startCond();
    begin
      bit s;
      int lows;
      lows = 0;
      for (int i = 7; i >= 0; i--) begin
        clockBit(WRONG[i], s);
      end
      clockBit(1'b1, s); if (!s) lows++;
      for (int i = 0; i < 9; i++) begin
        clockBit(1'b1, s); if (!s) lows++;
      end
      chk(lows == 0, "R2 wrong chip no drive", lows, 0);
    end
    stopCond();

    // R9: protected write is refused and starts no cycle
    protectIn = 1'b1;
    startCond();
    sendByte(DEVW, ack); chk(ack, "R9 select ack", ack, 1);
    sendByte(8'h10, ack); chk(ack, "R9 address ack", ack, 1);
    sendByte(8'h5A, ack); chk(!ack, "R9 data not acked", ack, 0);
    stopCond();
    pollReady(polls, waited);
    chk(polls == 1, "R9 no programming cycle", polls, 1);
    protectIn = 1'b0;
    // counter still 0x10 and content unchanged
    startCond();
    sendByte(DEVR, ack); chk(ack, "R9 read select ack", ack, 1);
    recvByte(1'b0, b);
    chk(b == pat(16), "R9 content kept, counter not advanced", b, pat(16));
    stopCond();

    // R4: write wrapping from 255 to 0
    startCond();
    sendByte(DEVW, ack);
    sendByte(8'hFF, ack);
    sendByte(8'h3C, ack); chk(ack, "R4 wrap byte 0 ack", ack, 1);
    sendByte(8'hC3, ack); chk(ack, "R4 wrap byte 1 ack", ack, 1);
    stopCond();
    pollReady(polls, waited);
    chk(polls > 1, "R8 busy after short write", polls, 2);
    startCond();
    sendByte(DEVW, ack);
    sendByte(8'hFF, ack);
    startCond();
    sendByte(DEVR, ack);
    recvByte(1'b1, b); chk(b == 8'h3C, "R4 data at 255", b, 8'h3C);
    recvByte(1'b0, b); chk(b == 8'hC3, "R4 wrapped data at 0", b, 8'hC3);
    stopCond();

    // R1: start in the middle of a data byte aborts it
    startCond();
    sendByte(DEVW, ack);
    sendByte(8'h20, ack); chk(ack, "R1 address ack", ack, 1);
    begin
      bit s;
      for (int i = 0; i < 4; i++) clockBit(1'b0, s);
    end
    startCond();
    sendByte(DEVR, ack); chk(ack, "R1 select after restart", ack, 1);
    recvByte(1'b0, b);
    chk(b == pat(32), "R1 partial byte not stored", b, pat(32));
    stopCond();
    qwait();
    chk(sdaOeN === 1'b1, "R1 released after stop", int'(sdaOeN), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule